// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Configuration Loader

This block fills a 64-byte configuration shadow as soon as reset is released, so that the device identity and option fields are valid before the host can reach configuration space. When the enable input is high, it reads a 1 Kbit serial EEPROM that is organised as 16-bit words. The interface has four wires: an active-high chip select, a clock, a command line towards the EEPROM and a data line from it. The block issues one read command per word and writes each word into the shadow. The less significant byte goes to the even byte offset and the more significant byte to the next offset.

When the enable input is low, the block makes no EEPROM access and the shadow keeps its built-in defaults. A busy output tells the host interface to retry configuration accesses until the load has finished. A done output marks that the shadow is final.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, the outputs are: chip select 0, serial clock 0, command line 0, busy 1 and done 0.
- R2: If the enable input is low at the first clock after reset, done rises at that clock and busy falls with it. The chip select never rises after that reset.
- R3: In default mode the 16-bit fields, read little-endian at the byte offsets shown, hold these values: 0x00 = 0x9845, 0x02 = 0x9710, 0x2C = 0x0014, 0x2E = 0x1000. Byte 0x3F holds 0x01 and all other bytes hold 0x00.
- R4: In load mode the block reads words 0 to 31 in ascending order. Each read sends, MSB first, a start bit 1, the opcode 10 and a 6-bit word address. The EEPROM takes each bit on a rising edge of the serial clock.
- R5: After the command, one dummy slot is clocked and then 16 data bits, MSB first. The block samples each bit just before the falling edge of the serial clock. Word k is stored with its bits 7:0 at byte 2k and its bits 15:8 at byte 2k+1. The device ID (offset 0x00), vendor ID (0x02), UART-A gap (0x04), interrupt mask (0x05), UART-B gap (0x10), subsystem IDs (0x2C and 0x2E) and interrupt pin (0x3F) therefore come from words 0, 1, 2, 2, 8, 22, 23 and 31.
- R6: While the chip select is high, each high phase and each low phase of the serial clock lasts exactly HALF_DIV system clocks. The serial clock is never high while the chip select is low.
- R7: Between two word reads, and before the first one, the chip select stays low for at least 2*HALF_DIV system clocks, which is one full serial clock period.
- R8: Busy stays high and done stays low until the last word has been stored. After that, done stays high, the chip select stays low and the shadow does not change.
- R9: The enable input is sampled only at the first clock after reset. Changing it during a load does not stop the load and does not alter the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_en_i | input | 1 | 1 = load from EEPROM, 0 = keep defaults |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Command bits to the EEPROM |
| shadow_o | output | 512 | Configuration shadow; byte i is at bits 8i+7:8i |
| busy_o | output | 1 | Load in progress; the host should retry |
| done_o | output | 1 | Shadow contents are final |

## Verification
The assertions assume two things about the inputs. The EEPROM changes its data line only right after a rising serial clock edge. The loader never starts a word read while the previous one is still running, which the sequencer ensures by design. The bench EEPROM model follows the first assumption: it drives a bit only on a rising edge, decodes the nine command bits before it drives anything, and otherwise holds the line at zero. The enable input is changed only at the falling system clock edge. In one run it is toggled in the middle of a load, to show that the first-cycle sample is the only one that counts.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [1:0] {LD_BOOT, LD_WAIT, LD_DONE} ld_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_GAP, RD_BITS} rd_state_e;

  localparam logic [1:0] RD_OPCODE = 2'b10;

  // built-in shadow contents used when the EEPROM is disabled
  function automatic logic [7:0] dflt_byte(input int unsigned idx);
    case (idx)
      'h00:    return 8'h45;
      'h01:    return 8'h98;
      'h02:    return 8'h10;
      'h03:    return 8'h97;
      'h2C:    return 8'h14;
      'h2F:    return 8'h10;
      'h3F:    return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ee_tick_gen.sv
module ee_tick_gen #(
  parameter int unsigned HALF_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_word_rd.sv
module ee_word_rd
  import cfg_ld_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned HALF_DIV = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ee_do_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int unsigned CMD_W   = 3 + ADDR_W;
  localparam int unsigned NBITS   = CMD_W + 1 + WORD_W;
  localparam int unsigned IDX_W   = $clog2(NBITS + 1);
  localparam int unsigned GAP_MIN = 2 * HALF_DIV;
  localparam int unsigned LOW_W   = $clog2(GAP_MIN + 1);
  localparam int unsigned HI_W    = $clog2(HALF_DIV + 1);

  rd_state_e         state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] shift_q;
  logic              half_q;
  logic              tick;

  ee_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      cmd_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      half_q  <= 1'b0;
      cs_o    <= 1'b0;
      sk_o    <= 1'b0;
      di_o    <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        RD_IDLE: if (start_i) begin
          cmd_q   <= {1'b1, RD_OPCODE, addr_i};
          half_q  <= 1'b0;
          state_q <= RD_GAP;
        end
        RD_GAP: if (tick) begin
          if (half_q) begin
            cs_o    <= 1'b1;
            idx_q   <= '0;
            di_o    <= cmd_q[CMD_W-1];
            cmd_q   <= cmd_q << 1;
            state_q <= RD_BITS;
          end else begin
            half_q <= 1'b1;
          end
        end
        RD_BITS: if (tick) begin
          if (!sk_o) begin
            sk_o <= 1'b1;
          end else begin
            sk_o <= 1'b0;
            if (idx_q >= IDX_W'(CMD_W + 1)) shift_q <= {shift_q[WORD_W-2:0], ee_do_i};
            if (idx_q == IDX_W'(NBITS - 1)) begin
              cs_o    <= 1'b0;
              di_o    <= 1'b0;
              done_o  <= 1'b1;
              state_q <= RD_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              di_o  <= cmd_q[CMD_W-1];
              cmd_q <= cmd_q << 1;
            end
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign word_o = shift_q;

  // timing monitors for the assertions
  logic [LOW_W-1:0] low_cnt_q;
  logic [HI_W-1:0]  hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      hi_cnt_q  <= '0;
    end else begin
      if (cs_o)                            low_cnt_q <= '0;
      else if (low_cnt_q != LOW_W'(GAP_MIN)) low_cnt_q <= low_cnt_q + 1'b1;
      hi_cnt_q <= sk_o ? hi_cnt_q + 1'b1 : '0;
    end
  end

  a_r6_sk_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);

  a_r6_sk_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sk_o) |-> hi_cnt_q == HI_W'(HALF_DIV));

  a_r7_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> low_cnt_q == LOW_W'(GAP_MIN));

  a_r4_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == RD_IDLE) && !cs_o);

endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow
  import cfg_ld_pkg::*;
#(
  parameter int unsigned NBYTES = 64,
  parameter int unsigned WORD_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [$clog2(NBYTES/(WORD_W/8))-1:0] widx_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [NBYTES*8-1:0]     bytes_o
);
  localparam int unsigned BPW    = WORD_W / 8;
  localparam int unsigned WIDX_W = $clog2(NBYTES / BPW);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [7:0]        RST_VAL = dflt_byte(g);
    localparam logic [WIDX_W-1:0] MY_WORD = WIDX_W'(g / BPW);
    localparam int unsigned       LANE    = g % BPW;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          bytes_o[8*g +: 8] <= RST_VAL;
      else if (wr_i && widx_i == MY_WORD)  bytes_o[8*g +: 8] <= wdata_i[8*LANE +: 8];
    end
  end
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfg_ld_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 32,
  parameter int unsigned CFG_BYTES = 64,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned WORD_W    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ee_en_i,
  input  logic                   ee_do_i,
  output logic                   ee_cs_o,
  output logic                   ee_sk_o,
  output logic                   ee_di_o,
  output logic [CFG_BYTES*8-1:0] shadow_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int unsigned NWORDS = CFG_BYTES / (WORD_W / 8);
  localparam int unsigned WIDX_W = $clog2(NWORDS);

  ld_state_e         state_q;
  logic [WIDX_W-1:0] word_q;
  logic              start_q;
  logic              rd_done;
  logic [WORD_W-1:0] rd_word;
  logic              wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_BOOT;
      word_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        LD_BOOT: begin
          if (ee_en_i) begin
            start_q <= 1'b1;
            state_q <= LD_WAIT;
          end else begin
            state_q <= LD_DONE;
          end
        end
        LD_WAIT: if (rd_done) begin
          if (word_q == WIDX_W'(NWORDS - 1)) begin
            state_q <= LD_DONE;
          end else begin
            word_q  <= word_q + 1'b1;
            start_q <= 1'b1;
          end
        end
        default: state_q <= LD_DONE;
      endcase
    end
  end

  assign wr     = (state_q == LD_WAIT) && rd_done;
  assign done_o = (state_q == LD_DONE);
  assign busy_o = !done_o;

  ee_word_rd #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .HALF_DIV (HALF_DIV)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .addr_i  (ADDR_W'(word_q)),
    .ee_do_i (ee_do_i),
    .cs_o    (ee_cs_o),
    .sk_o    (ee_sk_o),
    .di_o    (ee_di_o),
    .word_o  (rd_word),
    .done_o  (rd_done)
  );

  cfg_shadow #(
    .NBYTES (CFG_BYTES),
    .WORD_W (WORD_W)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .widx_i  (word_q),
    .wdata_i (rd_word),
    .bytes_o (shadow_o)
  );

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(shadow_o));

  a_r8_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ee_cs_o && !ee_sk_o);

  a_r2_no_access_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LD_BOOT && !ee_en_i) |=> done_o && !ee_cs_o);

  a_r8_busy_while_reading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_cs_o |-> busy_o && !done_o);

endmodule

// File: tb/cfg_eeprom_loader_tb_top.sv
module cfg_eeprom_loader_tb_top;
  localparam int unsigned HALF = 4;
  localparam int unsigned NB   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ee_do = 1'b0;
  logic cs, sk, di, busy, done;
  logic [NB*8-1:0] shadow;

  always #10 clk = ~clk;

  cfg_eeprom_loader #(.HALF_DIV(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ee_en_i(en), .ee_do_i(ee_do),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di),
    .shadow_o(shadow), .busy_o(busy), .done_o(done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // EEPROM model contents
  logic [15:0] mem [64];
  task automatic fill_mem(input int seed);
    for (int a = 0; a < 64; a++)
      mem[a] = 16'((seed * 16'h1357) ^ (a * 16'h0B1D) ^ (a << 9) ^ a);
  endtask

  // scoreboard of expected read commands
  logic [8:0] exp_q [$];
  task automatic push_cmds();
    for (int a = 0; a < NB / 2; a++) exp_q.push_back({1'b1, 2'b10, 6'(a)});
  endtask

  int edge_n = 0;
  logic [8:0] cmd_sh = '0;
  logic [5:0] cur_a = '0;
  int cs_rises = 0;

  always @(negedge cs) begin
    edge_n = 0;
    ee_do  = 1'b0;
  end

  always @(posedge sk) begin
    if (cs) begin
      edge_n++;
      if (edge_n <= 9) cmd_sh = {cmd_sh[7:0], di};
      if (edge_n == 9) begin
        cur_a = cmd_sh[5:0];
        if (exp_q.size() == 0) chk("R4", "unexpected command", {23'd0, cmd_sh}, 32'h1ff);
        else chk("R4", "read command", {23'd0, cmd_sh}, {23'd0, exp_q.pop_front()});
      end
      if (edge_n == 10) ee_do = 1'b0;
      else if (edge_n >= 11 && edge_n <= 26) ee_do = mem[cur_a][26 - edge_n];
      else ee_do = 1'b0;
    end
  end

  // serial timing monitor
  int hi_run = 0, lo_run = 0, gap_run = 0;
  int hi_bad = 0, lo_bad = 0, min_gap = 1000000, sk_nocs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sk && !cs) sk_nocs++;
      if (sk) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != HALF) hi_bad++;
        hi_run = 0;
      end
      if (cs && !sk) lo_run++;
      else begin
        if (sk && lo_run != 0 && lo_run != HALF) lo_bad++;
        lo_run = 0;
      end
      if (!cs) gap_run++;
      else begin
        if (gap_run != 0) begin
          cs_rises++;
          if (gap_run < min_gap) min_gap = gap_run;
        end
        gap_run = 0;
      end
    end
  end

  function automatic logic [15:0] fld(input int off);
    return {shadow[8*(off+1) +: 8], shadow[8*off +: 8]};
  endfunction

  task automatic boot(input logic en_v);
    @(negedge clk);
    rst_n = 1'b0;
    en = en_v;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk("R1", "cs in reset", {31'd0, cs}, 0);
    chk("R1", "sk in reset", {31'd0, sk}, 0);
    chk("R1", "di in reset", {31'd0, di}, 0);
    chk("R1", "busy in reset", {31'd0, busy}, 1);
    chk("R1", "done in reset", {31'd0, done}, 0);
    hi_run = 0; lo_run = 0; gap_run = 0; hi_bad = 0; lo_bad = 0;
    min_gap = 1000000; sk_nocs = 0; cs_rises = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(req, "load finished in time", {31'd0, done}, 1);
  endtask

  task automatic check_timing();
    chk("R6", "sk high width errors", 32'(hi_bad), 0);
    chk("R6", "sk low width errors", 32'(lo_bad), 0);
    chk("R6", "sk high without cs", 32'(sk_nocs), 0);
    chk("R7", "cs gap at least one sk period", {31'd0, min_gap >= 2 * HALF}, 1);
    chk("R4", "word reads seen", 32'(cs_rises), 32);
    chk("R4", "commands left unissued", 32'(exp_q.size()), 0);
  endtask

  task automatic check_image(input string req);
    for (int b = 0; b < NB; b++) begin
      logic [15:0] w;
      w = mem[b / 2];
      chk(req, $sformatf("byte %0d", b), {24'd0, shadow[8*b +: 8]},
          {24'd0, (b % 2) ? w[15:8] : w[7:0]});
    end
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NB*8-1:0] snap;
    // default mode: R2, R3
    fill_mem(1);
    boot(1'b0);
    @(negedge clk);
    chk("R2", "done one clock after reset", {31'd0, done}, 1);
    chk("R2", "busy one clock after reset", {31'd0, busy}, 0);
    chk("R3", "device id", {16'd0, fld('h00)}, 32'h9845);
    chk("R3", "vendor id", {16'd0, fld('h02)}, 32'h9710);
    chk("R3", "subsystem id", {16'd0, fld('h2C)}, 32'h0014);
    chk("R3", "subsystem vendor", {16'd0, fld('h2E)}, 32'h1000);
    chk("R3", "interrupt pin", {24'd0, shadow[8*'h3F +: 8]}, 32'h01);
    begin
      int nz = 0;
      for (int b = 0; b < NB; b++)
        if (!(b inside {0, 1, 2, 3, 'h2C, 'h2F, 'h3F}) && shadow[8*b +: 8] != 0) nz++;
      chk("R3", "other bytes zero", 32'(nz), 0);
    end
    snap = shadow;
    en = 1'b1;
    repeat (200) @(negedge clk);
    chk("R2", "cs never rose", 32'(cs_rises), 0);
    chk("R8", "shadow stable after done", {31'd0, shadow == snap}, 1);

    // load mode, pattern A: R4 R5 R6 R7 R8
    fill_mem(7);
    boot(1'b1);
    push_cmds();
    repeat (100) @(negedge clk);
    chk("R8", "busy during load", {31'd0, busy}, 1);
    chk("R8", "done during load", {31'd0, done}, 0);
    wait_done("R5");
    check_timing();
    check_image("R5");
    chk("R5", "device id", {16'd0, fld('h00)}, {16'd0, mem[0]});
    chk("R5", "vendor id", {16'd0, fld('h02)}, {16'd0, mem[1]});
    chk("R5", "uart a gap", {24'd0, shadow[8*'h04 +: 8]}, {24'd0, mem[2][7:0]});
    chk("R5", "irq mask", {24'd0, shadow[8*'h05 +: 8]}, {24'd0, mem[2][15:8]});
    chk("R5", "uart b gap", {24'd0, shadow[8*'h10 +: 8]}, {24'd0, mem[8][7:0]});
    chk("R5", "subsystem id", {16'd0, fld('h2C)}, {16'd0, mem[22]});
    chk("R5", "subsystem vendor", {16'd0, fld('h2E)}, {16'd0, mem[23]});
    chk("R5", "interrupt pin", {24'd0, shadow[8*'h3F +: 8]}, {24'd0, mem[31][15:8]});
    snap = shadow;
    repeat (300) @(negedge clk);
    chk("R8", "shadow stable after load", {31'd0, shadow == snap}, 1);
    chk("R8", "cs low after load", {31'd0, cs}, 0);
    chk("R8", "done held", {31'd0, done}, 1);

    // load mode, pattern B with enable dropped mid-load: R9
    fill_mem(42);
    mem[0] = 16'hFFFF;
    mem[31] = 16'h0000;
    boot(1'b1);
    push_cmds();
    repeat (50) @(negedge clk);
    en = 1'b0;
    repeat (500) @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b0;
    wait_done("R9");
    check_timing();
    check_image("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule